// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block holds sixteen 64-bit general-purpose registers and lets each one be reached through several overlapping views: the whole register, its low double word (32 bits), its low word (16 bits), its low byte, or, for the first four registers only, a separate high byte at bits 15:8. Every register has only one copy of storage. A narrow view is a window onto the bits of that storage.

There is one combinational read port and one write port. The write takes effect on the clock edge. Each port carries a register index, a two-bit size code and a high-byte select. The write port also carries data and an enable. Byte access is asymmetric: every register has a low byte, but only indices below `NUM_HIGH` have a high byte. A request that asks for a high byte where none exists, or that pairs the high-byte select with any size other than byte, raises an illegal flag on that port. An illegal request changes no register.

Top module: `rf_alias_regfile`

## Requirements
- R1: After reset, all registers read as zero through the full 64-bit view.
- R2: The size code is 0 for byte, 1 for word (16 bits), 2 for double word (32 bits) and 3 for the full 64 bits. A legal 64-bit write stores all of `wr_data`, and a 64-bit read returns the whole register.
- R3: A legal 32-bit write stores `wr_data[31:0]` in bits 31:0 and clears bits 63:32.
- R4: A legal 16-bit write replaces bits 15:0 only. A legal low-byte write (high select 0) replaces bits 7:0 only. All other bits are kept.
- R5: A legal high-byte write (size byte, high select 1, index 0 to 3) stores `wr_data[7:0]` in bits 15:8 and keeps every other bit.
- R6: A narrow read returns the selected bits zero-extended to 64 bits. A high-byte read returns bits 15:8 in `rd_data[7:0]`, with zeros above.
- R7: A request is illegal when its high select is 1 and either its index is 4 or more or its size is not byte. An illegal write raises `wr_illegal` in the cycle it is presented and changes no register. An illegal read raises `rd_illegal` and returns zero.
- R8: Low-byte access is legal for every index from 0 to 15, including 4 to 15.
- R9: A write is visible to reads from the cycle after its clock edge. A read of the register being written in the same cycle returns the old value.
- R10: When `wr_enable` is 0, no register changes and `wr_illegal` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all registers |
| wr_enable | input | 1 | Write request |
| wr_index | input | 4 | Register being written |
| wr_size | input | 2 | Write view size code |
| wr_high | input | 1 | Write targets bits 15:8 |
| wr_data | input | 64 | Write data, right-aligned |
| wr_illegal | output | 1 | Current write request is not allowed |
| rd_index | input | 4 | Register being read |
| rd_size | input | 2 | Read view size code |
| rd_high | input | 1 | Read targets bits 15:8 |
| rd_data | output | 64 | Read data, zero-extended |
| rd_illegal | output | 1 | Current read request is not allowed |

## Verification
The bench builds the block with its defaults: sixteen 64-bit registers, of which the first four have a high byte. With these values the bench can reach the high-byte boundary between index 3 and index 4, the last register at index 15, and the zero-extension of bits 63:32. Each view is written over a register that already holds a known pattern, so that any lane the write should have kept but changed shows up. The bench also presents a write and a read to the same register in the same cycle, to show that the read returns the old value.

// File: rtl/rf_alias_pkg.sv
package rf_alias_pkg;

    typedef enum logic [1:0] {
        VIEW_B8  = 2'd0,
        VIEW_B16 = 2'd1,
        VIEW_B32 = 2'd2,
        VIEW_B64 = 2'd3
    } view_size_e;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int DWORD_W = 32;

endpackage

// File: rtl/rf_access_check.sv
module rf_access_check
    import rf_alias_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int NUM_HIGH = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0] index,
    input  view_size_e       size,
    input  logic             high,
    output logic             bad
);

    logic no_high_lane;
    logic wrong_size;

    always_comb begin
        no_high_lane = (index >= IDX_W'(NUM_HIGH));
        wrong_size   = (size != VIEW_B8);
        bad          = high && (no_high_lane || wrong_size);
    end

endmodule

// File: rtl/rf_lane_merge.sv
module rf_lane_merge
    import rf_alias_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_data,
    input  view_size_e        size,
    input  logic              high,
    output logic [DATA_W-1:0] merged
);

    always_comb begin
        merged = old_val;
        unique case (size)
            VIEW_B8: begin
                if (high) begin
                    merged[WORD_W-1:BYTE_W] = new_data[BYTE_W-1:0];
                end else begin
                    merged[BYTE_W-1:0] = new_data[BYTE_W-1:0];
                end
            end
            VIEW_B16: merged[WORD_W-1:0] = new_data[WORD_W-1:0];
            VIEW_B32: begin
                merged                = '0;
                merged[DWORD_W-1:0]   = new_data[DWORD_W-1:0];
            end
            default:  merged = new_data;
        endcase
    end

endmodule

// File: rtl/rf_lane_extract.sv
module rf_lane_extract
    import rf_alias_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] word_in,
    input  view_size_e        size,
    input  logic              high,
    input  logic              blocked,
    output logic [DATA_W-1:0] view_out
);

    always_comb begin
        view_out = '0;
        if (!blocked) begin
            unique case (size)
                VIEW_B8: begin
                    if (high) begin
                        view_out[BYTE_W-1:0] = word_in[WORD_W-1:BYTE_W];
                    end else begin
                        view_out[BYTE_W-1:0] = word_in[BYTE_W-1:0];
                    end
                end
                VIEW_B16: view_out[WORD_W-1:0]  = word_in[WORD_W-1:0];
                VIEW_B32: view_out[DWORD_W-1:0] = word_in[DWORD_W-1:0];
                default:  view_out = word_in;
            endcase
        end
    end

endmodule

// File: rtl/rf_alias_regfile.sv
module rf_alias_regfile
    import rf_alias_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 64,
    parameter int NUM_HIGH = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [1:0]        wr_size,
    input  logic              wr_high,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal,
    input  logic [IDX_W-1:0]  rd_index,
    input  logic [1:0]        rd_size,
    input  logic              rd_high,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_illegal
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] gpr;
    } rf_state_t;

    rf_state_t st_d, st_q;

    view_size_e        wr_view, rd_view;
    logic              wr_bad, rd_bad;
    logic [DATA_W-1:0] wr_old, wr_merged, rd_word;

    assign wr_view = view_size_e'(wr_size);
    assign rd_view = view_size_e'(rd_size);

    rf_access_check #(.NUM_REGS(NUM_REGS), .NUM_HIGH(NUM_HIGH)) u_wr_check (
        .index (wr_index),
        .size  (wr_view),
        .high  (wr_high),
        .bad   (wr_bad)
    );

    rf_access_check #(.NUM_REGS(NUM_REGS), .NUM_HIGH(NUM_HIGH)) u_rd_check (
        .index (rd_index),
        .size  (rd_view),
        .high  (rd_high),
        .bad   (rd_bad)
    );

    assign wr_old  = st_q.gpr[wr_index];
    assign rd_word = st_q.gpr[rd_index];

    rf_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .old_val  (wr_old),
        .new_data (wr_data),
        .size     (wr_view),
        .high     (wr_high),
        .merged   (wr_merged)
    );

    rf_lane_extract #(.DATA_W(DATA_W)) u_extract (
        .word_in  (rd_word),
        .size     (rd_view),
        .high     (rd_high),
        .blocked  (rd_bad),
        .view_out (rd_data)
    );

    assign wr_illegal = wr_enable && wr_bad;
    assign rd_illegal = rd_bad;

    always_comb begin
        st_d = st_q;
        if (wr_enable && !wr_bad) begin
            st_d.gpr[wr_index] = wr_merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rf_alias_regfile_chk.sv
module rf_alias_regfile_chk
    import rf_alias_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 64,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_enable,
    input logic [IDX_W-1:0]                wr_index,
    input logic [1:0]                      wr_size,
    input logic                            wr_high,
    input logic [DATA_W-1:0]               wr_data,
    input logic                            wr_illegal,
    input logic [DATA_W-1:0]               rd_data,
    input logic                            rd_illegal,
    input logic [NUM_REGS-1:0][DATA_W-1:0] gpr
);

    // R7: rejected write leaves every register untouched
    assert_illegal_write_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> $stable(gpr));

    // R7: rejected read returns zero
    assert_illegal_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> (rd_data == '0));

    // R10: no enable, no change
    assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |=> $stable(gpr));

    // R10: idle write port never flags
    assert_idle_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |-> !wr_illegal);

    // R3: double word write clears the upper half
    assert_dword_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && !wr_illegal && wr_size == 2'd2)
        |=> (gpr[$past(wr_index)][DATA_W-1:DWORD_W] == '0));

    // R4: low byte write keeps bits above 7
    assert_byte_keeps_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && !wr_illegal && wr_size == 2'd0 && !wr_high)
        |=> (gpr[$past(wr_index)][DATA_W-1:BYTE_W] == $past(gpr[wr_index][DATA_W-1:BYTE_W])));

    // R5: high byte write lands in bits 15:8
    assert_high_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && !wr_illegal && wr_high)
        |=> (gpr[$past(wr_index)][WORD_W-1:BYTE_W] == $past(wr_data[BYTE_W-1:0])));

    // R2: full write stores all bits
    assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && !wr_illegal && wr_size == 2'd3)
        |=> (gpr[$past(wr_index)] == $past(wr_data)));

endmodule

bind rf_alias_regfile rf_alias_regfile_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_enable  (wr_enable),
    .wr_index   (wr_index),
    .wr_size    (wr_size),
    .wr_high    (wr_high),
    .wr_data    (wr_data),
    .wr_illegal (wr_illegal),
    .rd_data    (rd_data),
    .rd_illegal (rd_illegal),
    .gpr        (st_q.gpr)
);

// File: tb/rf_alias_regfile_bench.sv
module rf_alias_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_enable = 1'b0;
    logic [3:0]  wr_index = '0;
    logic [1:0]  wr_size = '0;
    logic        wr_high = 1'b0;
    logic [63:0] wr_data = '0;
    logic        wr_illegal;
    logic [3:0]  rd_index = '0;
    logic [1:0]  rd_size = 2'd3;
    logic        rd_high = 1'b0;
    logic [63:0] rd_data;
    logic        rd_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    logic last_wr_ill;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    rf_alias_regfile u_rf_alias_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_enable  (wr_enable),
        .wr_index   (wr_index),
        .wr_size    (wr_size),
        .wr_high    (wr_high),
        .wr_data    (wr_data),
        .wr_illegal (wr_illegal),
        .rd_index   (rd_index),
        .rd_size    (rd_size),
        .rd_high    (rd_high),
        .rd_data    (rd_data),
        .rd_illegal (rd_illegal)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [1:0] sz,
                            input logic hi, input logic [63:0] d, input logic en = 1'b1);
        @(negedge clk);
        wr_index  = idx;
        wr_size   = sz;
        wr_high   = hi;
        wr_data   = d;
        wr_enable = en;
        #1 last_wr_ill = wr_illegal;
        @(negedge clk);
        wr_enable = 1'b0;
        wr_high   = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] idx, input logic [1:0] sz,
                           input logic hi, output logic [63:0] d, output logic ill);
        rd_index = idx;
        rd_size  = sz;
        rd_high  = hi;
        #1;
        d   = rd_data;
        ill = rd_illegal;
        rd_high = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] d; logic il;
        for (int i = 0; i < 16; i++) begin
            do_read(4'(i), 2'd3, 1'b0, d, il);
            check("R1 reset value", d, 64'h0);
        end
    endtask

    task automatic t_full();
        logic [63:0] d; logic il;
        do_write(4'd5, 2'd3, 1'b0, 64'hDEAD_BEEF_0BAD_F00D);
        do_read(4'd5, 2'd3, 1'b0, d, il);
        check("R2 full write/read", d, 64'hDEAD_BEEF_0BAD_F00D);
        do_write(4'd15, 2'd3, 1'b0, 64'h8000_0000_0000_0001);
        do_read(4'd15, 2'd3, 1'b0, d, il);
        check("R2 last register", d, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_dword();
        logic [63:0] d; logic il;
        do_write(4'd2, 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(4'd2, 2'd2, 1'b0, 64'hAAAA_AAAA_1234_5678);
        do_read(4'd2, 2'd3, 1'b0, d, il);
        check("R3 dword zero-extend", d, 64'h0000_0000_1234_5678);
    endtask

    task automatic t_word_byte();
        logic [63:0] d; logic il;
        do_write(4'd9, 2'd3, 1'b0, 64'hAAAA_AAAA_AAAA_AAAA);
        do_write(4'd9, 2'd1, 1'b0, 64'h5555_5555_5555_BEEF);
        do_read(4'd9, 2'd3, 1'b0, d, il);
        check("R4 word merge", d, 64'hAAAA_AAAA_AAAA_BEEF);
        do_write(4'd9, 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FF11);
        do_read(4'd9, 2'd3, 1'b0, d, il);
        check("R4 low byte merge", d, 64'hAAAA_AAAA_AAAA_BE11);
    endtask

    task automatic t_high();
        logic [63:0] d; logic il;
        do_write(4'd3, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF);
        do_write(4'd3, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FF5A);
        check("R5 high write legal flag", 64'(last_wr_ill), 64'h0);
        do_read(4'd3, 2'd3, 1'b0, d, il);
        check("R5 high byte merge", d, 64'h0123_4567_89AB_5AEF);
        do_read(4'd3, 2'd0, 1'b1, d, il);
        check("R6 high byte read", d, 64'h0000_0000_0000_005A);
        check("R6 high read legal", 64'(il), 64'h0);
        do_read(4'd3, 2'd0, 1'b0, d, il);
        check("R6 low byte read", d, 64'h0000_0000_0000_00EF);
        do_read(4'd3, 2'd1, 1'b0, d, il);
        check("R6 word read", d, 64'h0000_0000_0000_5AEF);
        do_read(4'd3, 2'd2, 1'b0, d, il);
        check("R6 dword read", d, 64'h0000_0000_89AB_5AEF);
        do_write(4'd0, 2'd3, 1'b0, 64'h0);
        do_write(4'd0, 2'd0, 1'b1, 64'h0000_0000_0000_00C7);
        do_read(4'd0, 2'd3, 1'b0, d, il);
        check("R5 high byte reg 0", d, 64'h0000_0000_0000_C700);
    endtask

    task automatic t_illegal();
        logic [63:0] d; logic il;
        do_write(4'd4, 2'd3, 1'b0, 64'h1111_2222_3333_4444);
        do_write(4'd4, 2'd0, 1'b1, 64'h0000_0000_0000_00FF);
        check("R7 high on reg 4 write flag", 64'(last_wr_ill), 64'h1);
        do_read(4'd4, 2'd3, 1'b0, d, il);
        check("R7 illegal write no effect", d, 64'h1111_2222_3333_4444);
        do_read(4'd4, 2'd0, 1'b1, d, il);
        check("R7 high on reg 4 read flag", 64'(il), 64'h1);
        check("R7 illegal read data", d, 64'h0);
        do_write(4'd1, 2'd3, 1'b0, 64'h7777_7777_7777_7777);
        do_write(4'd1, 2'd1, 1'b1, 64'h0);
        check("R7 high with word size flag", 64'(last_wr_ill), 64'h1);
        do_read(4'd1, 2'd3, 1'b0, d, il);
        check("R7 high with word size no effect", d, 64'h7777_7777_7777_7777);
        do_read(4'd1, 2'd2, 1'b1, d, il);
        check("R7 high with dword read flag", 64'(il), 64'h1);
    endtask

    task automatic t_low_all();
        logic [63:0] d; logic il;
        for (int i = 4; i < 16; i++) begin
            do_write(4'(i), 2'd3, 1'b0, 64'hC3C3_C3C3_C3C3_C3C3);
            do_write(4'(i), 2'd0, 1'b0, 64'(i * 7));
            check("R8 low byte write flag", 64'(last_wr_ill), 64'h0);
            do_read(4'(i), 2'd3, 1'b0, d, il);
            check("R8 low byte any reg", d, {56'hC3C3_C3C3_C3C3_C3, 8'(i * 7)});
        end
    endtask

    task automatic t_same_cycle();
        logic [63:0] d; logic il;
        do_write(4'd6, 2'd3, 1'b0, 64'h0000_0000_0000_0AAA);
        @(negedge clk);
        wr_index = 4'd6; wr_size = 2'd3; wr_high = 1'b0;
        wr_data = 64'h0000_0000_0000_0BBB; wr_enable = 1'b1;
        do_read(4'd6, 2'd3, 1'b0, d, il);
        check("R9 same-cycle read old", d, 64'h0000_0000_0000_0AAA);
        @(negedge clk);
        wr_enable = 1'b0;
        do_read(4'd6, 2'd3, 1'b0, d, il);
        check("R9 next-cycle read new", d, 64'h0000_0000_0000_0BBB);
    endtask

    task automatic t_idle();
        logic [63:0] d; logic il;
        do_write(4'd7, 2'd3, 1'b0, 64'h1234_1234_1234_1234);
        do_write(4'd7, 2'd3, 1'b0, 64'hFFFF_0000_FFFF_0000, 1'b0);
        do_read(4'd7, 2'd3, 1'b0, d, il);
        check("R10 disabled write", d, 64'h1234_1234_1234_1234);
        do_write(4'd8, 2'd0, 1'b1, 64'h0, 1'b0);
        check("R10 disabled illegal no flag", 64'(last_wr_ill), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_dword();
        t_word_byte();
        t_high();
        t_illegal();
        t_low_all();
        t_same_cycle();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule